// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block forms the second operand of a data-processing operation. It takes a 32-bit operand and an incoming carry flag, works out a shift kind and a shift amount, applies the shift, and returns the shifted value together with a shifter carry-out. The shift can be given in three ways. It can sit as an immediate field in a full-width instruction word. It can sit as an immediate field in a compressed-format 32-bit instruction word. Or it can be register-specified, with a 2-bit type and an 8-bit amount arriving on dedicated ports.

The immediate decode applies the usual special cases. A zero amount on a right shift means a shift of 32. Type 3 with a zero amount becomes a one-bit rotate through the carry. A fourth mode asks directly for a rotate through carry using the port amount. Any amount other than 1 in that mode is reported as invalid, and the result and carry are forced to zero.

A parameter chooses between a single registered output stage, with a one-cycle latency and a valid pulse, and a purely combinational path.

Top module: `shift_operand_unit`

## Requirements
- R1: `mode_i` selects the shift source: 0 = full-width immediate, 1 = compressed immediate, 2 = register-specified (`rs_type_i`, `rs_amt_i`), 3 = direct rotate-through-carry. In every mode the 2-bit type codes 0 = logical left, 1 = logical right, 2 = arithmetic right and 3 = rotate right. In mode 2, type 3 is always a plain rotate right, never a rotate through carry.
- R2: In mode 0 the type is `instr_i[6:5]` and the 5-bit amount is `instr_i[11:7]`. All other instruction bits and the register-shift ports are ignored.
- R3: In mode 1 the type is `instr_i[5:4]` and the amount is `{instr_i[14:12], instr_i[7:6]}`. All other instruction bits are ignored.
- R4: In modes 0 and 1, an amount of 0 means 32 for logical right and arithmetic right. Type 3 with amount 0 selects rotate-through-carry with an effective amount of 1. Logical left with amount 0 is a pass-through.
- R5: When the effective amount is 0, `result_o` equals the operand and `carry_o` equals `carry_i`.
- R6: Logical left by n (1..32) gives operand<<n with carry-out = operand bit (32−n). For n > 32 the result is 0 and the carry is 0.
- R7: Logical right by n (1..32) gives operand>>n with carry-out = operand bit (n−1). For n > 32 the result is 0 and the carry is 0.
- R8: Arithmetic right by n fills with the sign bit and gives carry-out = operand bit (n−1). For n ≥ 32 every result bit equals the sign and the carry equals the sign.
- R9: Rotate right uses n modulo 32. The carry-out is bit 31 of the rotated result, including when n is a non-zero multiple of 32.
- R10: Rotate-through-carry returns `{carry_i, operand[31:1]}` with carry-out = operand bit 0.
- R11: In mode 3, `rs_amt_i` = 1 performs rotate-through-carry. Any other amount sets `invalid_o`, with `result_o` = 0 and `carry_o` = 0. Modes 0 to 2 never set `invalid_o`.
- R12: With `REG_OUT`=1, the outputs update one cycle after a cycle with `valid_i` high, and `valid_o` is `valid_i` delayed by one cycle. The data outputs hold while `valid_i` is low. All outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample is valid |
| mode_i | input | 2 | Shift source select |
| instr_i | input | 32 | Instruction word holding immediate shift fields |
| rs_type_i | input | 2 | Register-specified shift type |
| rs_amt_i | input | 8 | Register-specified shift amount |
| operand_i | input | 32 | Value to shift |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Shifter carry-out |
| invalid_o | output | 1 | Illegal rotate-through-carry request |
| valid_o | output | 1 | Output is valid |

## Verification
The two functions that meet in one cycle are the immediate decode special cases and the carry generation of the shifter. A zero immediate on a right shift becomes a 32-bit shift, so the carry must come from operand bit 31. A zero immediate with type 3 becomes a rotate through carry, so the result must take `carry_i` into bit 31. Vectors with operands whose top and bottom bits differ from the incoming carry provoke both at once, and the result and carry are judged against hand-derived values. Register-specified amounts of exactly 32 and beyond, and the direct rotate-through-carry mode with legal and illegal amounts, are checked the same way.

// File: rtl/shift_operand_pkg.sv
package shift_operand_pkg;
  typedef enum logic [2:0] {
    K_LSL = 3'd0,
    K_LSR = 3'd1,
    K_ASR = 3'd2,
    K_ROR = 3'd3,
    K_RRX = 3'd4
  } shift_kind_e;

  typedef enum logic [1:0] {
    M_WIDE = 2'd0,
    M_COMP = 2'd1,
    M_REG  = 2'd2,
    M_RRX  = 2'd3
  } shift_mode_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_operand_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [1:0]       mode_i,
  input  logic [31:0]      instr_i,
  input  logic [1:0]       rs_type_i,
  input  logic [AMT_W-1:0] rs_amt_i,
  output shift_kind_e      kind_o,
  output logic [AMT_W-1:0] amt_o,
  output logic             invalid_o
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [1:0] imm_type;
  logic [4:0] imm5;

  always_comb begin
    if (mode_i == M_COMP) begin
      imm_type = instr_i[5:4];
      imm5     = {instr_i[14:12], instr_i[7:6]};
    end else begin
      imm_type = instr_i[6:5];
      imm5     = instr_i[11:7];
    end
  end

  always_comb begin
    kind_o    = K_LSL;
    amt_o     = '0;
    invalid_o = 1'b0;
    unique case (mode_i)
      M_WIDE, M_COMP: begin
        unique case (imm_type)
          2'd0: begin kind_o = K_LSL; amt_o = AMT_W'(imm5); end
          2'd1: begin kind_o = K_LSR; amt_o = (imm5 == 5'd0) ? FULL_AMT : AMT_W'(imm5); end
          2'd2: begin kind_o = K_ASR; amt_o = (imm5 == 5'd0) ? FULL_AMT : AMT_W'(imm5); end
          default: begin
            if (imm5 == 5'd0) begin
              kind_o = K_RRX;
              amt_o  = AMT_W'(1);
            end else begin
              kind_o = K_ROR;
              amt_o  = AMT_W'(imm5);
            end
          end
        endcase
      end
      M_REG: begin
        amt_o = rs_amt_i;
        unique case (rs_type_i)
          2'd0:    kind_o = K_LSL;
          2'd1:    kind_o = K_LSR;
          2'd2:    kind_o = K_ASR;
          default: kind_o = K_ROR;
        endcase
      end
      default: begin
        kind_o    = K_RRX;
        amt_o     = rs_amt_i;
        invalid_o = (rs_amt_i != AMT_W'(1));
      end
    endcase
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_operand_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  shift_kind_e       kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              invalid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int RW = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [2*DATA_W-1:0] lsl_w, lsr_w, asr_w, ror_w;
  logic [AMT_W-1:0]    asr_amt;
  logic [RW-1:0]       rot_amt;
  logic                over;

  assign over    = amt_i > FULL_AMT;
  assign asr_amt = (amt_i >= FULL_AMT) ? FULL_AMT : amt_i;
  assign rot_amt = amt_i[RW-1:0];

  assign lsl_w = {{DATA_W{1'b0}}, operand_i} << amt_i;
  assign lsr_w = {operand_i, {DATA_W{1'b0}}} >> amt_i;
  assign asr_w = $signed({operand_i, {DATA_W{1'b0}}}) >>> asr_amt;
  assign ror_w = {operand_i, operand_i} >> rot_amt;

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    if (invalid_i) begin
      result_o = '0;
      carry_o  = 1'b0;
    end else if (kind_i == K_RRX) begin
      result_o = {carry_i, operand_i[DATA_W-1:1]};
      carry_o  = operand_i[0];
    end else if (amt_i != '0) begin
      unique case (kind_i)
        K_LSL: begin
          result_o = over ? '0 : lsl_w[DATA_W-1:0];
          carry_o  = over ? 1'b0 : lsl_w[DATA_W];
        end
        K_LSR: begin
          result_o = over ? '0 : lsr_w[2*DATA_W-1:DATA_W];
          carry_o  = over ? 1'b0 : lsr_w[DATA_W-1];
        end
        K_ASR: begin
          result_o = asr_w[2*DATA_W-1:DATA_W];
          carry_o  = asr_w[DATA_W-1];
        end
        default: begin
          result_o = ror_w[DATA_W-1:0];
          carry_o  = ror_w[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shift_out_stage.sv
module shift_out_stage #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              invalid_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              invalid_o,
  output logic              valid_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o  <= '0;
        carry_o   <= 1'b0;
        invalid_o <= 1'b0;
        valid_o   <= 1'b0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          result_o  <= result_i;
          carry_o   <= carry_i;
          invalid_o <= invalid_i;
        end
      end
    end
  end else begin : g_comb
    assign result_o  = result_i;
    assign carry_o   = carry_i;
    assign invalid_o = invalid_i;
    assign valid_o   = valid_i;
  end
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
  import shift_operand_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [31:0]       instr_i,
  input  logic [1:0]        rs_type_i,
  input  logic [AMT_W-1:0]  rs_amt_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              invalid_o,
  output logic              valid_o
);
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt;
  logic              bad;
  logic [DATA_W-1:0] res_c;
  logic              cy_c;

  shift_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .mode_i    (mode_i),
    .instr_i   (instr_i),
    .rs_type_i (rs_type_i),
    .rs_amt_i  (rs_amt_i),
    .kind_o    (kind),
    .amt_o     (amt),
    .invalid_o (bad)
  );

  shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .kind_i    (kind),
    .amt_i     (amt),
    .invalid_i (bad),
    .operand_i (operand_i),
    .carry_i   (carry_i),
    .result_o  (res_c),
    .carry_o   (cy_c)
  );

  shift_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .result_i  (res_c),
    .carry_i   (cy_c),
    .invalid_i (bad),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .invalid_o (invalid_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/shift_operand_chk.sv
module shift_operand_chk #(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        mode_i,
  input logic [AMT_W-1:0]  rs_amt_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              invalid_o,
  input logic              valid_o
);
  AST_INVALID_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (result_o == '0) && !carry_o); // R11

  if (REG_OUT) begin : g_seq
    AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R12
    AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o); // R12
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(result_o) && $stable(carry_o)); // R12
    AST_RRX_BAD_AMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && (mode_i == 2'd3) && (rs_amt_i != AMT_W'(1)) |=> invalid_o); // R11
    AST_NO_FALSE_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && (mode_i != 2'd3) |=> !invalid_o); // R11
    AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && (mode_i == 2'd2) && (rs_amt_i == '0) |=>
      (result_o == $past(operand_i)) && (carry_o == $past(carry_i))); // R5
  end
endmodule

bind shift_operand_unit shift_operand_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .rs_amt_i  (rs_amt_i),
  .operand_i (operand_i),
  .carry_i   (carry_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .invalid_o (invalid_o),
  .valid_o   (valid_o)
);

// File: tb/sim_shift_operand_unit.sv
module sim_shift_operand_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] instr;
    logic [1:0]  rt;
    logic [7:0]  ra;
    logic [31:0] op;
    logic        cin;
    logic [31:0] res;
    logic        c;
    logic        inv;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd2, 32'h0, 2'd0, 8'd4,   32'h87654321, 1'b0, 32'h76543210, 1'b0, 1'b0, 8'd1},  // R1 LSL 4
    '{2'd2, 32'h0, 2'd1, 8'd4,   32'h00000008, 1'b0, 32'h00000000, 1'b1, 1'b0, 8'd7},  // R7
    '{2'd2, 32'h0, 2'd2, 8'd4,   32'h8765432A, 1'b0, 32'hF8765432, 1'b1, 1'b0, 8'd8},  // R8
    '{2'd2, 32'h0, 2'd3, 8'd36,  32'h87654328, 1'b0, 32'h88765432, 1'b1, 1'b0, 8'd9},  // R9 mod 32
    '{2'd2, 32'h0, 2'd0, 8'd32,  32'h00000001, 1'b0, 32'h00000000, 1'b1, 1'b0, 8'd6},  // R6 n=32
    '{2'd2, 32'h0, 2'd0, 8'd33,  32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 1'b0, 8'd6},  // R6 n>32
    '{2'd2, 32'h0, 2'd1, 8'd32,  32'h80000000, 1'b0, 32'h00000000, 1'b1, 1'b0, 8'd7},  // R7 n=32
    '{2'd2, 32'h0, 2'd1, 8'd40,  32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 1'b0, 8'd7},  // R7 n>32
    '{2'd2, 32'h0, 2'd2, 8'd200, 32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd8},  // R8 big
    '{2'd2, 32'h0, 2'd2, 8'd255, 32'h7FFFFFFF, 1'b1, 32'h00000000, 1'b0, 1'b0, 8'd8},  // R8 big pos
    '{2'd2, 32'h0, 2'd2, 8'd0,   32'h12345678, 1'b1, 32'h12345678, 1'b1, 1'b0, 8'd5},  // R5
    '{2'd2, 32'h0, 2'd3, 8'd32,  32'h80000001, 1'b0, 32'h80000001, 1'b1, 1'b0, 8'd9},  // R9 n=32
    '{2'd2, 32'h0, 2'd3, 8'd1,   32'h00000001, 1'b0, 32'h80000000, 1'b1, 1'b0, 8'd1},  // R1 type3=ROR
    '{2'd0, 32'h80000180, 2'd3, 8'hAA, 32'hE0000001, 1'b0, 32'h00000008, 1'b1, 1'b0, 8'd2}, // R2
    '{2'd0, 32'h00000020, 2'd3, 8'hAA, 32'h80000000, 1'b0, 32'h00000000, 1'b1, 1'b0, 8'd4}, // R4 LSR #0
    '{2'd0, 32'h00000040, 2'd3, 8'hAA, 32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 8'd4}, // R4 ASR #0
    '{2'd0, 32'h00000060, 2'd3, 8'hAA, 32'h00000003, 1'b1, 32'h80000001, 1'b1, 1'b0, 8'd10},// R10
    '{2'd0, 32'h00000460, 2'd3, 8'hAA, 32'h87654321, 1'b0, 32'h21876543, 1'b0, 1'b0, 8'd2}, // R2 ROR 8
    '{2'd0, 32'h00000000, 2'd3, 8'hAA, 32'h00000055, 1'b1, 32'h00000055, 1'b1, 1'b0, 8'd4}, // R4 LSL #0
    '{2'd1, 32'h00001050, 2'd3, 8'hAA, 32'h00000030, 1'b0, 32'h00000001, 1'b1, 1'b0, 8'd3}, // R3 LSR 5
    '{2'd1, 32'h00000F30, 2'd3, 8'hAA, 32'h00000002, 1'b0, 32'h00000001, 1'b0, 1'b0, 8'd3}, // R3 RRX
    '{2'd1, 32'h000070E0, 2'd3, 8'hAA, 32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd3}, // R3 ASR 31
    '{2'd3, 32'h0, 2'd0, 8'd1,   32'h00000001, 1'b0, 32'h00000000, 1'b1, 1'b0, 8'd11}, // R11 legal
    '{2'd3, 32'h0, 2'd0, 8'd0,   32'h12345678, 1'b1, 32'h00000000, 1'b0, 1'b1, 8'd11}, // R11 amt 0
    '{2'd3, 32'h0, 2'd0, 8'd2,   32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 1'b1, 8'd11}  // R11 amt 2
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] instr_i = '0;
  logic [1:0]  rs_type_i = '0;
  logic [7:0]  rs_amt_i = '0;
  logic [31:0] operand_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o, invalid_o, valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_operand_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .instr_i(instr_i), .rs_type_i(rs_type_i), .rs_amt_i(rs_amt_i),
    .operand_i(operand_i), .carry_i(carry_i), .result_o(result_o),
    .carry_o(carry_o), .invalid_o(invalid_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode_i = v.mode; instr_i = v.instr; rs_type_i = v.rt; rs_amt_i = v.ra;
    operand_i = v.op; carry_i = v.cin;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    valid_i = 1'b1;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R12: reset holds outputs at zero
    chk("R12 reset", {result_o, carry_o, invalid_o, valid_o}, 35'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      valid_i = 1'b1;
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i),
          {result_o, carry_o, invalid_o, valid_o},
          {VECS[i].res, VECS[i].c, VECS[i].inv, 1'b1});
    end

    // R12: idle input leaves outputs held, valid drops
    valid_i = 1'b0;
    drive(VECS[0]);
    @(posedge clk); @(negedge clk);
    chk("R12 hold", {result_o, carry_o, invalid_o, valid_o},
        {VECS[NV-1].res, VECS[NV-1].c, VECS[NV-1].inv, 1'b0});

    // R12: output appears exactly one cycle after the valid cycle
    valid_i = 1'b1;
    drive(VECS[2]);
    @(posedge clk); #1;
    valid_i = 1'b0;
    drive(VECS[1]);
    chk("R12 latency", {result_o, carry_o, invalid_o, valid_o},
        {VECS[2].res, VECS[2].c, 1'b0, 1'b1});
    @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R12 after", {result_o, carry_o, invalid_o, valid_o},
        {VECS[2].res, VECS[2].c, 1'b0, 1'b0});

    // R2: mode 0 ignores register-shift ports and compressed field bits
    valid_i = 1'b1;
    mode_i = 2'd0; instr_i = 32'h7FFF_F01F; rs_type_i = 2'd1; rs_amt_i = 8'd9;
    operand_i = 32'hA5A5_A5A5; carry_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 ignore", {result_o, carry_o, invalid_o, valid_o},
        {32'hA5A5_A5A5, 1'b1, 1'b0, 1'b1});

    // R5/R9: register ROR by 0 passes operand and carry-in
    mode_i = 2'd2; rs_type_i = 2'd3; rs_amt_i = 8'd0; operand_i = 32'h0F0F_0F0F; carry_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R5 ror0", {result_o, carry_o, invalid_o, valid_o},
        {32'h0F0F_0F0F, 1'b0, 1'b0, 1'b1});

    // R11: invalid clears after a legal request in another mode
    mode_i = 2'd3; rs_amt_i = 8'd7; operand_i = 32'hFFFF_FFFF; carry_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 bad", {result_o, carry_o, invalid_o}, {32'h0, 1'b0, 1'b1});
    mode_i = 2'd2; rs_type_i = 2'd0; rs_amt_i = 8'd1; operand_i = 32'h8000_0001; carry_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R11 R6 clear", {result_o, carry_o, invalid_o}, {32'h0000_0002, 1'b1, 1'b0});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule